// File: doc/BRIEF.md
# Instruction Breakpoint and Data Watchpoint Match Unit

This block watches the instruction fetch stream and the data access stream of a processor core and raises debug exception requests toward the exception unit. It holds a set of breakpoint entries, each a word address with an enable bit, and a set of watchpoint entries, each an exact byte address with a two-bit access-type code. Software loads all entries through a simple register write port.

Every cycle the fetch PC is compared with every armed breakpoint, and the data address and read/write strobes are compared with every watchpoint whose type allows that direction. Both requests are combinational, so the exception unit can stop a matching data access in the same cycle, before memory changes. When a watchpoint and a breakpoint both match, only the watchpoint request is raised. Per-entry hit vectors are provided directly and as a copy registered one cycle later.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every entry is disabled: both requests and all four hit vectors are zero while no configuration has been written.
- R2: Breakpoint entry i hits when fetchValid is high, its enable (bit 0 of its register) is set, and fetchPc bits 31:2 equal register bits 31:2; fetchPc bits 1:0 are ignored. bpExcReq and bpHitVec bit i respond in the same cycle.
- R3: A breakpoint entry written with bit 0 clear never hits, whatever its address bits.
- R4: Watchpoint type codes, held in bits [2i+1:2i] of the type register for entry i: 2'b00 off, 2'b01 read, 2'b10 write, 2'b11 read or write. An entry hits when dataAddr matches and (dataRd with type bit 0) or (dataWr with type bit 1); wpExcReq is raised combinationally in the same cycle as the access strobe.
- R5: Watchpoint comparison uses all address bits, so a neighbouring byte address never hits.
- R6: When any watchpoint hits, bpExcReq stays low even if a breakpoint hits; bpHitVec still reports the breakpoint entries that match.
- R7: Several entries matching together produce a single request line per kind, with bit i of each hit vector set for every matching entry i.
- R8: bpHitVecQ and wpHitVecQ equal bpHitVec and wpHitVec of the previous cycle.
- R9: Register select map: 0 to 3 breakpoint entries, 4 to 7 watchpoint addresses, 8 the watchpoint type register; a write takes effect from the next cycle, and writes to any other select change nothing.
- R10: With fetchValid low no breakpoint hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 4 | Configuration register select |
| cfgWdata | input | 32 | Configuration write data |
| fetchValid | input | 1 | Fetch PC is valid this cycle |
| fetchPc | input | 32 | Fetch program counter |
| dataRd | input | 1 | Data read strobe |
| dataWr | input | 1 | Data write strobe |
| dataAddr | input | 32 | Data access byte address |
| bpExcReq | output | 1 | Breakpoint exception request |
| wpExcReq | output | 1 | Watchpoint exception request |
| bpHitVec | output | 4 | Per-entry breakpoint hits, same cycle |
| wpHitVec | output | 4 | Per-entry watchpoint hits, same cycle |
| bpHitVecQ | output | 4 | Breakpoint hits, one cycle delayed |
| wpHitVecQ | output | 4 | Watchpoint hits, one cycle delayed |

## Verification
The hardest case to reach is a single cycle in which a configuration write, a fetch and a data access all touch the same entries, with more than one watchpoint and more than one breakpoint matching at once, so that priority, the per-entry vectors and the write-next-cycle rule all meet. Directed sequences first set up each such coincidence by hand, then a long stretch drives writes, fetches and accesses drawn from a small pool of addresses so that collisions of that kind recur many times, each cycle compared with a behavioural model.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             bpWe;
    logic             wpAddrWe;
    logic             wpTypeWe;
    logic [IDX_W-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/dbg_match_ctrl.sv
module dbg_match_ctrl
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int SEL_W  = 4
) (
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [NUM_BP-1:0] bpHit,
  input  logic [NUM_WP-1:0] wpHit,
  output cfgStrobe_t        strobe,
  output logic              bpExcReq,
  output logic              wpExcReq
);
  localparam int WP_BASE  = NUM_BP;
  localparam int TYPE_SEL = NUM_BP + NUM_WP;

  always_comb begin
    strobe = '0;
    if (cfgWe) begin
      if (int'(cfgSel) < WP_BASE) begin
        strobe.bpWe = 1'b1;
        strobe.idx  = IDX_W'(int'(cfgSel));
      end else if (int'(cfgSel) < TYPE_SEL) begin
        strobe.wpAddrWe = 1'b1;
        strobe.idx      = IDX_W'(int'(cfgSel) - WP_BASE);
      end else if (int'(cfgSel) == TYPE_SEL) begin
        strobe.wpTypeWe = 1'b1;
      end
    end
  end

  // Watchpoint takes precedence; breakpoint only when no watchpoint is pending.
  always_comb begin
    wpExcReq = |wpHit;
    bpExcReq = (|bpHit) & ~wpExcReq;
  end
endmodule

// File: rtl/dbg_match_dp.sv
module dbg_match_dp
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              dataRd,
  input  logic              dataWr,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic [NUM_BP-1:0] bpHit,
  output logic [NUM_WP-1:0] wpHit,
  output logic [NUM_BP-1:0] bpHitQ,
  output logic [NUM_WP-1:0] wpHitQ
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] WORD_MASK = {{WORD_W{1'b1}}, 2'b00};

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic              bpEn;
    logic [WORD_W-1:0] bpWord;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bpEn   <= 1'b0;
        bpWord <= '0;
      end else if (strobe.bpWe && strobe.idx == IDX_W'(i)) begin
        bpEn   <= cfgWdata[0];
        bpWord <= cfgWdata[ADDR_W-1:2];
      end
    end

    assign bpHit[i] = fetchValid & bpEn & ((fetchPc & WORD_MASK) == {bpWord, 2'b00});
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    logic [ADDR_W-1:0] wpAddr;
    logic [1:0]        wpType;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wpAddr <= '0;
        wpType <= 2'b00;
      end else begin
        if (strobe.wpAddrWe && strobe.idx == IDX_W'(i)) wpAddr <= cfgWdata;
        if (strobe.wpTypeWe) wpType <= cfgWdata[2*i +: 2];
      end
    end

    assign wpHit[i] = (wpAddr == dataAddr) & ((dataRd & wpType[0]) | (dataWr & wpType[1]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpHitQ <= '0;
      wpHitQ <= '0;
    end else begin
      bpHitQ <= bpHit;
      wpHitQ <= wpHit;
    end
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32,
  localparam int SEL_W = $clog2(NUM_BP + NUM_WP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              dataRd,
  input  logic              dataWr,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic              bpExcReq,
  output logic              wpExcReq,
  output logic [NUM_BP-1:0] bpHitVec,
  output logic [NUM_WP-1:0] wpHitVec,
  output logic [NUM_BP-1:0] bpHitVecQ,
  output logic [NUM_WP-1:0] wpHitVecQ
);
  cfgStrobe_t strobe;

  dbg_match_ctrl #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .SEL_W(SEL_W)) ctrl_i (
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .bpHit    (bpHitVec),
    .wpHit    (wpHitVec),
    .strobe   (strobe),
    .bpExcReq (bpExcReq),
    .wpExcReq (wpExcReq)
  );

  dbg_match_dp #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWdata   (cfgWdata),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc),
    .dataRd     (dataRd),
    .dataWr     (dataWr),
    .dataAddr   (dataAddr),
    .bpHit      (bpHitVec),
    .wpHit      (wpHitVec),
    .bpHitQ     (bpHitVecQ),
    .wpHitQ     (wpHitVecQ)
  );
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk #(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic              dataRd,
  input logic              dataWr,
  input logic              bpExcReq,
  input logic              wpExcReq,
  input logic [NUM_BP-1:0] bpHitVec,
  input logic [NUM_WP-1:0] wpHitVec,
  input logic [NUM_BP-1:0] bpHitVecQ,
  input logic [NUM_WP-1:0] wpHitVecQ
);
  p_bp_needs_fetch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|bpHitVec) |-> fetchValid);

  p_wp_needs_access_r4: assert property (@(posedge clk) disable iff (!rstN)
    wpExcReq |-> (dataRd | dataWr));

  p_wp_over_bp_r6: assert property (@(posedge clk) disable iff (!rstN)
    wpExcReq |-> !bpExcReq);

  p_any_wp_requests_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|wpHitVec) |-> wpExcReq);

  p_bp_req_has_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    bpExcReq |-> (|bpHitVec));

  p_bp_delayed_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bpHitVecQ == $past(bpHitVec)));

  p_wp_delayed_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wpHitVecQ == $past(wpHitVec)));
endmodule

bind dbg_match_unit dbg_match_unit_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .fetchValid (fetchValid),
  .dataRd     (dataRd),
  .dataWr     (dataWr),
  .bpExcReq   (bpExcReq),
  .wpExcReq   (wpExcReq),
  .bpHitVec   (bpHitVec),
  .wpHitVec   (wpHitVec),
  .bpHitVecQ  (bpHitVecQ),
  .wpHitVecQ  (wpHitVecQ)
);

// File: tb/dbg_match_unit_tb.sv
module dbg_match_unit_tb_top;
  localparam int NB = 4;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        dataRd = 1'b0;
  logic        dataWr = 1'b0;
  logic [31:0] dataAddr = '0;
  logic        bpExcReq, wpExcReq;
  logic [NB-1:0] bpHitVec, bpHitVecQ;
  logic [NW-1:0] wpHitVec, wpHitVecQ;

  always #5 clk = ~clk;

  dbg_match_unit dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .dataRd(dataRd), .dataWr(dataWr),
    .dataAddr(dataAddr), .bpExcReq(bpExcReq), .wpExcReq(wpExcReq),
    .bpHitVec(bpHitVec), .wpHitVec(wpHitVec), .bpHitVecQ(bpHitVecQ), .wpHitVecQ(wpHitVecQ)
  );

  // Behavioural reference state
  logic [31:0] mBp[NB];
  logic [31:0] mWpAddr[NW];
  logic [1:0]  mWpType[NW];
  logic [NB-1:0] mBpPrev;
  logic [NW-1:0] mWpPrev;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(string tag, string field, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, field, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NB; i++) mBp[i] = '0;
    for (int i = 0; i < NW; i++) begin mWpAddr[i] = '0; mWpType[i] = 2'b00; end
    mBpPrev = '0;
    mWpPrev = '0;
  endtask

  task automatic step(string tag);
    logic [NB-1:0] eB;
    logic [NW-1:0] eW;
    logic eWr, eBr;
    @(negedge clk);
    for (int i = 0; i < NB; i++)
      eB[i] = fetchValid && mBp[i][0] && (mBp[i][31:2] == fetchPc[31:2]);
    for (int i = 0; i < NW; i++)
      eW[i] = (mWpAddr[i] == dataAddr) &&
              ((dataRd && (mWpType[i] == 2'b01 || mWpType[i] == 2'b11)) ||
               (dataWr && (mWpType[i] == 2'b10 || mWpType[i] == 2'b11)));
    eWr = (eW != 0);
    eBr = (eB != 0) && !eWr;
    chk(tag, "R2/R6 bpExcReq", 32'(bpExcReq), 32'(eBr));
    chk(tag, "R4 wpExcReq", 32'(wpExcReq), 32'(eWr));
    chk(tag, "R7 bpHitVec", 32'(bpHitVec), 32'(eB));
    chk(tag, "R7 wpHitVec", 32'(wpHitVec), 32'(eW));
    chk(tag, "R8 bpHitVecQ", 32'(bpHitVecQ), 32'(mBpPrev));
    chk(tag, "R8 wpHitVecQ", 32'(wpHitVecQ), 32'(mWpPrev));
    @(posedge clk);
    mBpPrev = eB;
    mWpPrev = eW;
    if (cfgWe) begin
      if (cfgSel < NB) mBp[cfgSel] = cfgWdata;
      else if (cfgSel < NB + NW) mWpAddr[cfgSel - NB] = cfgWdata;
      else if (cfgSel == NB + NW)
        for (int i = 0; i < NW; i++) mWpType[i] = cfgWdata[2*i +: 2];
    end
    #1;
  endtask

  task automatic idle();
    cfgWe = 0; fetchValid = 0; dataRd = 0; dataWr = 0;
  endtask

  task automatic wr(int sel, logic [31:0] d, string tag);
    idle();
    cfgWe = 1; cfgSel = 4'(sel); cfgWdata = d;
    step(tag);
    cfgWe = 0;
  endtask

  task automatic fetch(logic [31:0] pc, string tag);
    idle(); fetchValid = 1; fetchPc = pc; step(tag);
  endtask

  task automatic access(logic rd, logic wrs, logic [31:0] a, string tag);
    idle(); dataRd = rd; dataWr = wrs; dataAddr = a; step(tag);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      finishRun();
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    rstN = 1;
    // R1: nothing armed after reset
    fetch(32'h0, "R1");
    access(1, 1, 32'h0, "R1");
    // R9: write is not visible in its own cycle
    idle(); cfgWe = 1; cfgSel = 4'd0; cfgWdata = 32'h0000_1001;
    fetchValid = 1; fetchPc = 32'h0000_1000; step("R9");
    cfgWe = 0;
    fetch(32'h0000_1000, "R2");
    fetch(32'h0000_1003, "R2");
    fetch(32'h0000_1004, "R2");
    idle(); fetchPc = 32'h0000_1000; step("R10");
    // R3: disarm
    wr(0, 32'h0000_1000, "R3");
    fetch(32'h0000_1000, "R3");
    // R4/R5: watchpoint types and exact byte compare
    wr(4, 32'h0000_2001, "R4");
    wr(8, 32'h0000_0001, "R4");
    access(1, 0, 32'h0000_2001, "R4");
    access(0, 1, 32'h0000_2001, "R4");
    access(1, 0, 32'h0000_2000, "R5");
    access(1, 0, 32'h0000_2002, "R5");
    wr(8, 32'h0000_0002, "R4");
    access(1, 0, 32'h0000_2001, "R4");
    access(0, 1, 32'h0000_2001, "R4");
    wr(8, 32'h0000_0003, "R4");
    access(1, 0, 32'h0000_2001, "R4");
    access(0, 1, 32'h0000_2001, "R4");
    wr(8, 32'h0000_0000, "R4");
    access(1, 1, 32'h0000_2001, "R4");
    // R6: priority
    wr(8, 32'h0000_00ff, "R6");
    wr(1, 32'h0000_3001, "R6");
    idle(); fetchValid = 1; fetchPc = 32'h0000_3000; dataWr = 1; dataAddr = 32'h0000_2001;
    step("R6");
    // R7: several entries at once
    wr(2, 32'h0000_3001, "R7");
    wr(5, 32'h0000_2001, "R7");
    idle(); fetchValid = 1; fetchPc = 32'h0000_3002; step("R7");
    idle(); fetchValid = 1; fetchPc = 32'h0000_3002; dataRd = 1; dataAddr = 32'h0000_2001;
    step("R7");
    // R9: unmapped selects change nothing
    wr(12, 32'hffff_ffff, "R9");
    wr(15, 32'h0000_0000, "R9");
    idle(); fetchValid = 1; fetchPc = 32'h0000_3000; step("R9");
    access(1, 1, 32'h0000_2001, "R9");
    // Mixed random traffic over a small address pool
    for (int n = 0; n < 600; n++) begin
      logic [31:0] pool[4];
      pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1001;
      pool[2] = 32'h0000_2001; pool[3] = 32'h0000_3003;
      cfgWe = ($urandom_range(0, 3) == 0);
      cfgSel = 4'($urandom_range(0, 10));
      cfgWdata = (cfgSel == 4'd8) ? $urandom() : (pool[$urandom_range(0, 3)] | 32'($urandom_range(0, 1)));
      fetchValid = $urandom_range(0, 1);
      fetchPc = pool[$urandom_range(0, 3)];
      dataRd = $urandom_range(0, 1);
      dataWr = $urandom_range(0, 1);
      dataAddr = pool[$urandom_range(0, 3)];
      step("R7");
    end
    idle();
    finishRun();
  end
endmodule